// File: doc/BRIEF.md
# Serial Flash Whole-Device Erase Sequencer

This block sits on the host side of a serial flash connected over SPI. It erases the entire flash device. A one-cycle start request launches three transactions. The first is a single-byte frame that unlocks writes. The second is a single-byte frame carrying the whole-device erase opcode; the erase itself begins only when chip select is released at the end of this frame. The third is a status-read frame that stays open, with chip select low, while the sequencer clocks out one status byte after another. It watches the busy flag in each byte.

When a status byte shows the flash idle, the sequencer closes the frame and pulses a completion flag. If the flash is still busy after a set number of status bytes, it closes the frame and pulses an error flag instead. In both cases the last status byte read is left on the status output.

When the sequencer is idle it also accepts a stand-alone status-read request. This opens a frame, reads one status byte, closes the frame and presents that byte with a one-cycle valid strobe. The SPI bus runs in mode 0 with the most significant bit first. The serial clock is derived from the system clock through a parameterised divider. Chip select is always held high for a minimum number of system clocks between frames.

Top module: `spi_erase_seq`

## Requirements
- R1: While reset is asserted and right after it is released, chip select (`spi_cs_n_o`) is high, `spi_sck_o` is low, and `done_o`, `error_o` and `status_valid_o` are low.
- R2: A start pulse received while idle produces a first frame containing exactly one byte, the write-unlock opcode 0x06.
- R3: The second frame contains exactly one byte, the erase opcode given by parameter `ERASE_OP` (0x60 or 0xC7, default 0xC7). Chip select rises immediately after the eighth bit of that byte.
- R4: The third frame begins with the status-read opcode 0x05 and then carries consecutive status bytes under the same chip-select-low period, without resending the opcode. The sequencer sends 0x00 on `spi_mosi_o` while it reads.
- R5: The bus works in SPI mode 0. SCK is low whenever chip select is high. MOSI carries bit 7 first and is captured by the flash on the rising SCK edge. MISO is sampled on the rising SCK edge, with bit 7 arriving first.
- R6: Chip select stays high for at least `CS_GAP` system clocks between any two frames.
- R7: The first status byte whose bit 0 (busy) is 0 ends the poll. Chip select is raised, `done_o` pulses for exactly one cycle, and `status_o` holds that byte.
- R8: If `MAX_POLLS` status bytes in a row all have bit 0 set, chip select is raised after the last of them, `error_o` pulses for one cycle, `done_o` stays low, and the poll frame holds exactly `MAX_POLLS` status bytes.
- R9: Start and status-read requests received while a sequence is running are ignored. No extra frame is issued and only one completion or error pulse results.
- R10: A status-read request received while idle produces one frame: 0x05 followed by one status byte. It then gives a one-cycle `status_valid_o` pulse with that byte on `status_o`, and no erase frames are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the erase sequence |
| status_req_i | input | 1 | One-cycle request for a single status read |
| done_o | output | 1 | One-cycle pulse: erase finished, busy flag clear |
| error_o | output | 1 | One-cycle pulse: poll limit reached while still busy |
| status_valid_o | output | 1 | One-cycle pulse: stand-alone status byte is ready |
| status_o | output | 8 | Last status byte read from the flash |
| spi_cs_n_o | output | 1 | Chip select to the flash, active low |
| spi_sck_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is the timeout path. It needs a flash that stays busy longer than the poll limit and keeps streaming status bytes within one open frame. The bench includes a behavioural flash that decodes each frame when chip select rises. It arms a busy countdown, set per test, only after it has seen an unlock frame followed by an erase frame. It then shifts out a fresh status byte every eight clocks while the read frame is held open.

The timeout leaves the model flash still busy. A following stand-alone read therefore returns 0x01 instead of the reset value. This separates the stand-alone path from the erase path.

// File: rtl/spi_erase_seq_pkg.sv
package spi_erase_seq_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSTAT = 8'h05;
  localparam logic [7:0] OP_FILL = 8'h00;
  localparam int BUSY_BIT = 0;

  typedef struct packed {
    logic csLow;
    logic load;
    logic [7:0] txByte;
  } spiCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLOCK,
    ST_GAP_A,
    ST_ERASE,
    ST_GAP_B,
    ST_POLL_OP,
    ST_POLL_DAT,
    ST_RD_OP,
    ST_RD_DAT,
    ST_COOL
  } seqState_e;

endpackage

// File: rtl/spi_erase_seq_dp.sv
module spi_erase_seq_dp
  import spi_erase_seq_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  spiCmd_t    cmd,
  input  logic       misoIn,
  output logic       byteDone,
  output logic [7:0] rxByte,
  output logic       csN,
  output logic       sckOut,
  output logic       mosiOut
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active;
  logic             sckQ;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sckQ     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (cmd.load) begin
        active  <= 1'b1;
        sckQ    <= 1'b0;
        divCnt  <= '0;
        bitCnt  <= '0;
        txShift <= cmd.txByte;
      end else if (active) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sckQ) begin
            sckQ    <= 1'b1;
            rxShift <= {rxShift[6:0], misoIn};
          end else begin
            sckQ <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 3'd1;
              txShift <= {txShift[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign rxByte  = rxShift;
  assign csN     = ~cmd.csLow;
  assign sckOut  = sckQ;
  assign mosiOut = txShift[7];

endmodule

// File: rtl/spi_erase_seq_ctrl.sv
module spi_erase_seq_ctrl
  import spi_erase_seq_pkg::*;
#(
  parameter logic [7:0] ERASE_OP  = 8'hC7,
  parameter int         CS_GAP    = 2,
  parameter int         MAX_POLLS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       statusReq,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  output spiCmd_t    cmd,
  output logic       donePulse,
  output logic       errorPulse,
  output logic       statusValid,
  output logic [7:0] statusByte
);

  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(CS_GAP - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

  seqState_e         state;
  logic [GAP_W-1:0]  gapCnt;
  logic [POLL_W-1:0] pollCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cmd         <= '0;
      gapCnt      <= '0;
      pollCnt     <= '0;
      donePulse   <= 1'b0;
      errorPulse  <= 1'b0;
      statusValid <= 1'b0;
      statusByte  <= '0;
    end else begin
      cmd.load    <= 1'b0;
      donePulse   <= 1'b0;
      errorPulse  <= 1'b0;
      statusValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            cmd.load   <= 1'b1;
            cmd.txByte <= OP_WREN;
            cmd.csLow  <= 1'b1;
            state      <= ST_UNLOCK;
          end else if (statusReq) begin
            cmd.load   <= 1'b1;
            cmd.txByte <= OP_RDSTAT;
            cmd.csLow  <= 1'b1;
            state      <= ST_RD_OP;
          end
        end
        ST_UNLOCK: begin
          if (byteDone) begin
            cmd.csLow <= 1'b0;
            gapCnt    <= '0;
            state     <= ST_GAP_A;
          end
        end
        ST_GAP_A: begin
          if (gapCnt == GAP_LAST) begin
            cmd.load   <= 1'b1;
            cmd.txByte <= ERASE_OP;
            cmd.csLow  <= 1'b1;
            state      <= ST_ERASE;
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        ST_ERASE: begin
          if (byteDone) begin
            cmd.csLow <= 1'b0;
            gapCnt    <= '0;
            state     <= ST_GAP_B;
          end
        end
        ST_GAP_B: begin
          if (gapCnt == GAP_LAST) begin
            cmd.load   <= 1'b1;
            cmd.txByte <= OP_RDSTAT;
            cmd.csLow  <= 1'b1;
            state      <= ST_POLL_OP;
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        ST_POLL_OP: begin
          if (byteDone) begin
            cmd.load   <= 1'b1;
            cmd.txByte <= OP_FILL;
            pollCnt    <= '0;
            state      <= ST_POLL_DAT;
          end
        end
        ST_POLL_DAT: begin
          if (byteDone) begin
            statusByte <= rxByte;
            if (!rxByte[BUSY_BIT]) begin
              donePulse <= 1'b1;
              cmd.csLow <= 1'b0;
              gapCnt    <= '0;
              state     <= ST_COOL;
            end else if (pollCnt == POLL_LAST) begin
              errorPulse <= 1'b1;
              cmd.csLow  <= 1'b0;
              gapCnt     <= '0;
              state      <= ST_COOL;
            end else begin
              pollCnt    <= pollCnt + POLL_W'(1);
              cmd.load   <= 1'b1;
              cmd.txByte <= OP_FILL;
            end
          end
        end
        ST_RD_OP: begin
          if (byteDone) begin
            cmd.load   <= 1'b1;
            cmd.txByte <= OP_FILL;
            state      <= ST_RD_DAT;
          end
        end
        ST_RD_DAT: begin
          if (byteDone) begin
            statusByte  <= rxByte;
            statusValid <= 1'b1;
            cmd.csLow   <= 1'b0;
            gapCnt      <= '0;
            state       <= ST_COOL;
          end
        end
        ST_COOL: begin
          if (gapCnt == GAP_LAST) state <= ST_IDLE;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
  import spi_erase_seq_pkg::*;
#(
  parameter int         CLK_DIV   = 2,
  parameter logic [7:0] ERASE_OP  = 8'hC7,
  parameter int         CS_GAP    = 2,
  parameter int         MAX_POLLS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       status_req_i,
  output logic       done_o,
  output logic       error_o,
  output logic       status_valid_o,
  output logic [7:0] status_o,
  output logic       spi_cs_n_o,
  output logic       spi_sck_o,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i
);

  spiCmd_t    cmd;
  logic       byteDone;
  logic [7:0] rxByte;

  spi_erase_seq_ctrl #(
    .ERASE_OP (ERASE_OP),
    .CS_GAP   (CS_GAP),
    .MAX_POLLS(MAX_POLLS)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (start_i),
    .statusReq  (status_req_i),
    .byteDone   (byteDone),
    .rxByte     (rxByte),
    .cmd        (cmd),
    .donePulse  (done_o),
    .errorPulse (error_o),
    .statusValid(status_valid_o),
    .statusByte (status_o)
  );

  spi_erase_seq_dp #(
    .CLK_DIV(CLK_DIV)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .misoIn  (spi_miso_i),
    .byteDone(byteDone),
    .rxByte  (rxByte),
    .csN     (spi_cs_n_o),
    .sckOut  (spi_sck_o),
    .mosiOut (spi_mosi_o)
  );

endmodule

// File: rtl/spi_erase_seq_chk.sv
module spi_erase_seq_chk #(
  parameter int CS_GAP = 2
) (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n_o,
  input logic spi_sck_o,
  input logic done_o,
  input logic error_o,
  input logic status_valid_o
);

  localparam int CW = $clog2(CS_GAP + 2);
  logic [CW-1:0] highCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) highCnt <= CW'(CS_GAP);
    else if (!spi_cs_n_o) highCnt <= '0;
    else if (highCnt < CW'(CS_GAP)) highCnt <= highCnt + CW'(1);
  end

  assert_idle_sck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sck_o);

  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n_o) |-> highCnt >= CW'(CS_GAP));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_cs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> spi_cs_n_o);

  assert_error_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);

  assert_error_not_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(error_o && done_o));

  assert_status_valid_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid_o |-> (spi_cs_n_o && !done_o && !error_o));

endmodule

bind spi_erase_seq spi_erase_seq_chk #(.CS_GAP(CS_GAP)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .spi_cs_n_o    (spi_cs_n_o),
  .spi_sck_o     (spi_sck_o),
  .done_o        (done_o),
  .error_o       (error_o),
  .status_valid_o(status_valid_o)
);

// File: tb/spi_erase_seq_tb_top.sv
module spi_erase_seq_tb_top;

  localparam int         CLK_DIV   = 2;
  localparam logic [7:0] ERASE_OP  = 8'h60;
  localparam int         CS_GAP    = 2;
  localparam int         MAX_POLLS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic status_req_i = 1'b0;
  logic done_o, error_o, status_valid_o;
  logic [7:0] status_o;
  logic spi_cs_n_o, spi_sck_o, spi_mosi_o;
  logic spi_miso_i = 1'b0;

  always #4 clk = ~clk;

  spi_erase_seq #(
    .CLK_DIV(CLK_DIV), .ERASE_OP(ERASE_OP), .CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .status_req_i(status_req_i),
    .done_o(done_o), .error_o(error_o), .status_valid_o(status_valid_o),
    .status_o(status_o), .spi_cs_n_o(spi_cs_n_o), .spi_sck_o(spi_sck_o),
    .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i)
  );

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Behavioural flash model
  int         bitIdx = 0;
  int         byteCnt = 0;
  logic [7:0] shiftIn = 8'h00;
  logic [7:0] curOp = 8'h00;
  logic [7:0] outByte = 8'h00;
  logic       wel = 1'b0;
  int         busyLeft = 0;
  int         eraseBusy = 0;
  int         partialFrames = 0;
  logic [7:0] frameOp[$];
  int         frameLen[$];
  logic [7:0] lastStatus = 8'h00;

  always @(negedge spi_cs_n_o) begin
    bitIdx = 0;
    byteCnt = 0;
    curOp = 8'h00;
  end

  always @(posedge spi_sck_o) begin
    if (!spi_cs_n_o) begin
      shiftIn = {shiftIn[6:0], spi_mosi_o};
      bitIdx++;
      if (bitIdx == 8) begin
        bitIdx = 0;
        if (byteCnt == 0) curOp = shiftIn;
        byteCnt++;
      end
    end
  end

  always @(negedge spi_sck_o) begin
    if (!spi_cs_n_o && curOp == 8'h05 && byteCnt >= 1 && bitIdx == 0) begin
      outByte = {6'b0, wel, (busyLeft > 0)};
      lastStatus = outByte;
      if (busyLeft > 0) busyLeft--;
    end else if (bitIdx != 0) begin
      outByte = {outByte[6:0], 1'b0};
    end
    spi_miso_i = outByte[7];
  end

  always @(posedge spi_cs_n_o) begin
    if (bitIdx != 0) partialFrames++;
    if (byteCnt > 0) begin
      frameOp.push_back(curOp);
      frameLen.push_back(byteCnt);
      if (byteCnt == 1 && curOp == 8'h06) wel = 1'b1;
      if (byteCnt == 1 && (curOp == 8'h60 || curOp == 8'hC7) && wel) begin
        busyLeft = eraseBusy;
        wel = 1'b0;
      end
    end
    bitIdx = 0;
    byteCnt = 0;
  end

  // Per-clock monitor: mode 0 idle level (R5) and chip-select gaps (R6)
  int csHighRun = 100;
  int doneCnt = 0;
  int errCnt = 0;
  int validCnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n_o) begin
        check(!spi_sck_o, "R5 sck low while cs high", spi_sck_o, 0);
        csHighRun++;
      end else begin
        if (csHighRun != 0) check(csHighRun >= CS_GAP, "R6 cs high gap", csHighRun, CS_GAP);
        csHighRun = 0;
      end
      if (done_o) doneCnt++;
      if (error_o) errCnt++;
      if (status_valid_o) validCnt++;
    end
  end

  task automatic clearLog();
    frameOp.delete();
    frameLen.delete();
    doneCnt = 0;
    errCnt = 0;
    validCnt = 0;
    partialFrames = 0;
  endtask

  task automatic waitEnd(output bit gotDone, output bit gotErr);
    gotDone = 0;
    gotErr = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done_o || error_o || status_valid_o) begin
        gotDone = done_o;
        gotErr = error_o;
        return;
      end
    end
    check(0, "R7 sequence end reached", 0, 1);
  endtask

  task automatic runErase(input int busyN, input bit inject);
    bit gd, ge;
    bit expErr;
    int expLen;
    clearLog();
    eraseBusy = busyN;
    expErr = (busyN >= MAX_POLLS);
    expLen = expErr ? (1 + MAX_POLLS) : (busyN + 2);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    if (inject) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1;
      status_req_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      status_req_i = 1'b0;
      repeat (80) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    waitEnd(gd, ge);
    if (expErr) begin
      check(ge, "R8 error pulse on timeout", ge, 1);
      check(!gd, "R8 no done on timeout", gd, 0);
      check(status_o[0], "R8 last status busy", status_o, 1);
    end else begin
      check(gd, "R7 done pulse", gd, 1);
      check(status_o == lastStatus && !status_o[0], "R7 status byte", status_o, lastStatus);
    end
    check(spi_cs_n_o, "R7 cs high at end", spi_cs_n_o, 1);
    repeat (40) @(negedge clk);
    check(doneCnt == (expErr ? 0 : 1), "R7 single done pulse", doneCnt, expErr ? 0 : 1);
    check(errCnt == (expErr ? 1 : 0), "R8 single error pulse", errCnt, expErr ? 1 : 0);
    check(frameOp.size() == 3, "R9 frame count", frameOp.size(), 3);
    check(partialFrames == 0, "R5 whole bytes only", partialFrames, 0);
    if (frameOp.size() == 3) begin
      check(frameOp[0] == 8'h06 && frameLen[0] == 1, "R2 unlock frame", frameOp[0], 8'h06);
      check(frameOp[1] == ERASE_OP && frameLen[1] == 1, "R3 erase frame", frameOp[1], ERASE_OP);
      check(frameOp[2] == 8'h05, "R4 poll opcode", frameOp[2], 8'h05);
      check(frameLen[2] == expLen, expErr ? "R8 poll byte count" : "R4 poll byte count",
            frameLen[2], expLen);
    end
  endtask

  task automatic runStatus(input logic [7:0] expByte);
    bit gd, ge;
    clearLog();
    @(negedge clk) status_req_i = 1'b1;
    @(negedge clk) status_req_i = 1'b0;
    waitEnd(gd, ge);
    check(status_valid_o, "R10 status valid pulse", status_valid_o, 1);
    check(status_o == expByte, "R10 status byte", status_o, expByte);
    repeat (30) @(negedge clk);
    check(validCnt == 1, "R10 single valid pulse", validCnt, 1);
    check(frameOp.size() == 1, "R10 one frame", frameOp.size(), 1);
    if (frameOp.size() == 1)
      check(frameOp[0] == 8'h05 && frameLen[0] == 2, "R10 frame content", frameLen[0], 2);
    check(doneCnt == 0 && errCnt == 0, "R10 no erase result", doneCnt + errCnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spi_cs_n_o && !spi_sck_o, "R1 reset bus idle", {spi_cs_n_o, spi_sck_o}, 2'b10);
    check(!done_o && !error_o && !status_valid_o, "R1 reset flags low",
          {done_o, error_o, status_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n_o && !spi_sck_o && !done_o && !error_o, "R1 after release",
          {spi_cs_n_o, spi_sck_o, done_o, error_o}, 4'b1000);
    runStatus(8'h00);
    runErase(0, 1'b0);
    runErase(3, 1'b1);
    runErase(MAX_POLLS - 1, 1'b0);
    runErase(MAX_POLLS + 4, 1'b0);
    runStatus(8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule